// File: doc/BRIEF.md
# Key Scan Ghost Filter with Function-Layer Remap

This block post-processes the set of key contacts captured in a single scan of a row/column key matrix. Up to `SLOTS` entries arrive together, each with its own valid bit, a row number and a column number. The block turns every valid entry into a scancode, with the row in the high bits and the column in the low bits.

When the function-layer mode is on, entries matching the configured Fn scancode are removed from the list. If any Fn entry was present, every surviving code is moved into a second code layer by adding the matrix size. The surviving list is compacted to the low slots.

When ghost filtering is on and at least three keys remain, the block walks every key pair, one pair per cycle. It records whether any pair shares a row and whether any pair shares a column. If both are seen, the scan is flagged as discarded and the last accepted key list is presented again in its place.

A scan enters through a valid/ready handshake. `in_ready` is high only while the block is idle, so a new scan waits while a scan is being processed or a result is pending. The result leaves through a second valid/ready handshake. `out_valid` rising is the done strobe. The result stays valid and unchanged while `out_ready` is low. The mode pins and the Fn code are sampled in the cycle a scan is accepted.

Top module: `kgf_filter`

## Requirements
- R1: A scancode is the 4-bit row placed above the 3-bit column, {row, col}, giving bits 6:3 = row and bits 2:0 = col. Each output slot is 8 bits wide, slot k at bits 8k+7:8k of `out_codes`.
- R2: With `fn_layer_en` = 1, every valid entry whose scancode equals `fn_code` is dropped from the list, and `out_fn` is 1 for that scan.
- R3: With `fn_layer_en` = 0, an entry equal to `fn_code` is kept as an ordinary key, and `out_fn` is 0.
- R4: When Fn was dropped, 128 is added to every remaining code, so bit 7 of each used slot is set. The pair comparison uses only bits 6:0, and dropped Fn entries take no part in it.
- R5: Kept entries are packed into slots 0 upward in input slot order, skipping invalid slots. `out_count` is the number kept, and every slot at or above `out_count` reads 0.
- R6: The ghost check runs only when `ghost_en` = 1 and at least three keys remain. Otherwise `out_discard` is 0.
- R7: `out_discard` is 1 exactly when some pair of remaining keys shares a row and some pair, possibly a different one, shares a column.
- R8: On a discarded scan, `out_codes` and `out_count` repeat the last non-discarded result, which is all zero after reset.
- R9: `in_ready` is 1 only while idle and never together with `out_valid`. While `out_valid` = 1 and `out_ready` = 0, `out_valid`, `out_codes`, `out_count` and `out_discard` hold. Each accepted scan yields one result.
- R10: `out_valid` rises n(n-1)/2+1 clock edges after the accepting edge when the ghost check runs on n keys, and 1 edge after it otherwise.
- R11: After reset, `in_ready` = 1, `out_valid` = 0, `out_count` = 0, `out_codes` = 0 and `out_discard` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fn_layer_en | input | 1 | Enables Fn removal and remap |
| ghost_en | input | 1 | Enables the ghost check |
| fn_code | input | 7 | Scancode of the Fn key |
| in_valid | input | 1 | Scan offered |
| in_ready | output | 1 | Block idle, scan accepted when valid |
| in_slot_vld | input | 8 | Per-slot entry valid |
| in_rows | input | 32 | Row of slot k at bits 4k+3:4k |
| in_cols | input | 24 | Column of slot k at bits 3k+2:3k |
| out_valid | output | 1 | Result valid (done) |
| out_ready | input | 1 | Result consumed when valid |
| out_codes | output | 64 | Filtered scancodes, 8 bits per slot |
| out_count | output | 4 | Number of codes in the list |
| out_discard | output | 1 | Scan rejected as a ghost pattern |
| out_fn | output | 1 | Fn was among this scan's keys |

## Verification
Fn removal and the ghost decision act on the same scan. A scan whose Fn key would complete a shared-row plus shared-column pattern is sent with Fn mode on and then again with it off. With Fn mode on, the result must show two remapped codes and no discard. With Fn mode off, the result must be a discard that repeats the earlier two-code list. The random part draws rows, columns and the Fn code from narrow ranges, so that Fn hits, row matches and column matches often coincide in one scan. Every result is compared with a bench model of the whole rule.

// File: rtl/kgf_pkg.sv
package kgf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PAIRS = 2'd1,
    ST_DONE  = 2'd2
  } kgf_state_e;
endpackage

// File: rtl/kgf_compact.sv
module kgf_compact #(
  parameter int SLOTS = 8,
  parameter int ROW_W = 4,
  parameter int COL_W = 3,
  localparam int CODE_W = ROW_W + COL_W,
  localparam int CNT_W  = $clog2(SLOTS + 1)
) (
  input  logic [SLOTS-1:0]        slot_vld,
  input  logic [SLOTS*ROW_W-1:0]  rows,
  input  logic [SLOTS*COL_W-1:0]  cols,
  input  logic                    fn_layer_en,
  input  logic [CODE_W-1:0]       fn_code,
  output logic [SLOTS*CODE_W-1:0] list_codes,
  output logic [CNT_W-1:0]        list_cnt,
  output logic                    fn_seen
);
  logic [CODE_W-1:0] raw [SLOTS];
  logic [SLOTS-1:0]  is_fn;
  logic [SLOTS-1:0]  keep;

  for (genvar s = 0; s < SLOTS; s++) begin : gen_code
    assign raw[s]   = {rows[s*ROW_W +: ROW_W], cols[s*COL_W +: COL_W]};
    assign is_fn[s] = fn_layer_en && (raw[s] == fn_code);
    assign keep[s]  = slot_vld[s] && !is_fn[s];
  end

  assign fn_seen = |(slot_vld & is_fn);

  logic [SLOTS*CODE_W-1:0] packed_q;
  logic [CNT_W-1:0]        cnt_v;

  always_comb begin
    packed_q = '0;
    cnt_v    = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (keep[s]) begin
        packed_q[cnt_v*CODE_W +: CODE_W] = raw[s];
        cnt_v = cnt_v + CNT_W'(1);
      end
    end
  end

  assign list_codes = packed_q;
  assign list_cnt   = cnt_v;
endmodule

// File: rtl/kgf_pair_walk.sv
module kgf_pair_walk #(
  parameter int SLOTS = 8,
  parameter int ROW_W = 4,
  parameter int COL_W = 3,
  localparam int CODE_W = ROW_W + COL_W,
  localparam int CNT_W  = $clog2(SLOTS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    check,
  input  logic [SLOTS*CODE_W-1:0] codes,
  input  logic [CNT_W-1:0]        cnt,
  output logic                    fin,
  output logic                    row_hit,
  output logic                    col_hit
);
  logic             busy;
  logic [CNT_W-1:0] idx_a;
  logic [CNT_W-1:0] idx_b;
  logic [CODE_W-1:0] code_a;
  logic [CODE_W-1:0] code_b;
  logic             row_eq;
  logic             col_eq;
  logic             last_b;
  logic             last_a;

  assign code_a = codes[idx_a*CODE_W +: CODE_W];
  assign code_b = codes[idx_b*CODE_W +: CODE_W];
  assign row_eq = code_a[CODE_W-1:COL_W] == code_b[CODE_W-1:COL_W];
  assign col_eq = code_a[COL_W-1:0] == code_b[COL_W-1:0];
  assign last_b = idx_b == (cnt - CNT_W'(1));
  assign last_a = idx_a == (cnt - CNT_W'(2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      fin     <= 1'b0;
      row_hit <= 1'b0;
      col_hit <= 1'b0;
      idx_a   <= '0;
      idx_b   <= '0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        row_hit <= 1'b0;
        col_hit <= 1'b0;
        idx_a   <= '0;
        idx_b   <= CNT_W'(1);
        busy    <= check;
        fin     <= !check;
      end else if (busy) begin
        if (row_eq) row_hit <= 1'b1;
        if (col_eq) col_hit <= 1'b1;
        if (last_b) begin
          if (last_a) begin
            busy <= 1'b0;
            fin  <= 1'b1;
          end else begin
            idx_a <= idx_a + CNT_W'(1);
            idx_b <= idx_a + CNT_W'(2);
          end
        end else begin
          idx_b <= idx_b + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/kgf_remap.sv
module kgf_remap #(
  parameter int SLOTS = 8,
  parameter int ROW_W = 4,
  parameter int COL_W = 3,
  localparam int CODE_W = ROW_W + COL_W,
  localparam int OUT_W  = CODE_W + 1,
  localparam int CNT_W  = $clog2(SLOTS + 1)
) (
  input  logic [SLOTS*CODE_W-1:0] codes_in,
  input  logic [CNT_W-1:0]        cnt,
  input  logic                    layer_hi,
  output logic [SLOTS*OUT_W-1:0]  codes_out
);
  for (genvar s = 0; s < SLOTS; s++) begin : gen_slot
    assign codes_out[s*OUT_W +: OUT_W] = (CNT_W'(s) < cnt)
      ? {layer_hi, codes_in[s*CODE_W +: CODE_W]} : '0;
  end
endmodule

// File: rtl/kgf_filter.sv
module kgf_filter #(
  parameter int SLOTS = 8,
  parameter int ROW_W = 4,
  parameter int COL_W = 3,
  localparam int CODE_W = ROW_W + COL_W,
  localparam int OUT_W  = CODE_W + 1,
  localparam int CNT_W  = $clog2(SLOTS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fn_layer_en,
  input  logic                   ghost_en,
  input  logic [CODE_W-1:0]      fn_code,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [SLOTS-1:0]       in_slot_vld,
  input  logic [SLOTS*ROW_W-1:0] in_rows,
  input  logic [SLOTS*COL_W-1:0] in_cols,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [SLOTS*OUT_W-1:0] out_codes,
  output logic [CNT_W-1:0]       out_count,
  output logic                   out_discard,
  output logic                   out_fn
);
  import kgf_pkg::*;

  kgf_state_e state;

  logic [SLOTS*CODE_W-1:0] cmp_codes;
  logic [CNT_W-1:0]        cmp_cnt;
  logic                    cmp_fn;
  logic [SLOTS*CODE_W-1:0] cur_codes;
  logic [CNT_W-1:0]        cur_cnt;
  logic                    cur_fn;
  logic [SLOTS*OUT_W-1:0]  remap_codes;
  logic [SLOTS*OUT_W-1:0]  res_codes;
  logic [CNT_W-1:0]        res_cnt;
  logic                    res_discard;
  logic                    res_fn;
  logic                    accept;
  logic                    need_check;
  logic                    walk_fin;
  logic                    walk_row;
  logic                    walk_col;
  logic                    ghost;

  kgf_compact #(.SLOTS(SLOTS), .ROW_W(ROW_W), .COL_W(COL_W)) u_compact (
    .slot_vld    (in_slot_vld),
    .rows        (in_rows),
    .cols        (in_cols),
    .fn_layer_en (fn_layer_en),
    .fn_code     (fn_code),
    .list_codes  (cmp_codes),
    .list_cnt    (cmp_cnt),
    .fn_seen     (cmp_fn)
  );

  assign in_ready   = (state == ST_IDLE);
  assign accept     = in_valid && in_ready;
  assign need_check = ghost_en && (cmp_cnt >= CNT_W'(3));

  kgf_pair_walk #(.SLOTS(SLOTS), .ROW_W(ROW_W), .COL_W(COL_W)) u_walk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .check   (need_check),
    .codes   (cur_codes),
    .cnt     (cur_cnt),
    .fin     (walk_fin),
    .row_hit (walk_row),
    .col_hit (walk_col)
  );

  kgf_remap #(.SLOTS(SLOTS), .ROW_W(ROW_W), .COL_W(COL_W)) u_remap (
    .codes_in  (cur_codes),
    .cnt       (cur_cnt),
    .layer_hi  (cur_fn),
    .codes_out (remap_codes)
  );

  assign ghost = walk_row && walk_col;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cur_codes   <= '0;
      cur_cnt     <= '0;
      cur_fn      <= 1'b0;
      res_codes   <= '0;
      res_cnt     <= '0;
      res_discard <= 1'b0;
      res_fn      <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            cur_codes <= cmp_codes;
            cur_cnt   <= cmp_cnt;
            cur_fn    <= cmp_fn;
            state     <= ST_PAIRS;
          end
        end
        ST_PAIRS: begin
          if (walk_fin) begin
            res_discard <= ghost;
            res_fn      <= cur_fn;
            if (!ghost) begin
              res_codes <= remap_codes;
              res_cnt   <= cur_cnt;
            end
            state <= ST_DONE;
          end
        end
        ST_DONE: begin
          if (out_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign out_valid   = (state == ST_DONE);
  assign out_codes   = res_codes;
  assign out_count   = res_cnt;
  assign out_discard = res_discard;
  assign out_fn      = res_fn;
endmodule

// File: rtl/kgf_filter_chk.sv
module kgf_filter_chk #(
  parameter int SLOTS = 8,
  parameter int ROW_W = 4,
  parameter int COL_W = 3,
  localparam int CODE_W = ROW_W + COL_W,
  localparam int OUT_W  = CODE_W + 1,
  localparam int CNT_W  = $clog2(SLOTS + 1)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [SLOTS*OUT_W-1:0] out_codes,
  input logic [CNT_W-1:0]       out_count,
  input logic                   out_discard,
  input logic                   out_fn
);
  p_ready_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_codes)
      && $stable(out_count) && $stable(out_discard)));

  p_count_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_count <= CNT_W'(SLOTS));

  p_tail_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_count == '0) |-> (out_codes == '0));

  p_discard_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_valid) && out_discard) |-> ($stable(out_codes) && $stable(out_count)));

  p_layer_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_discard && out_count != '0) |-> (out_codes[OUT_W-1] == out_fn));
endmodule

bind kgf_filter kgf_filter_chk #(.SLOTS(SLOTS), .ROW_W(ROW_W), .COL_W(COL_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_codes   (out_codes),
  .out_count   (out_count),
  .out_discard (out_discard),
  .out_fn      (out_fn)
);

// File: tb/kgf_filter_tb_top.sv
module kgf_filter_tb_top;
  localparam int SLOTS = 8;
  localparam int ROW_W = 4;
  localparam int COL_W = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fn_layer_en = 1'b0;
  logic        ghost_en = 1'b0;
  logic [6:0]  fn_code = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_slot_vld = '0;
  logic [31:0] in_rows = '0;
  logic [23:0] in_cols = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_codes;
  logic [3:0]  out_count;
  logic        out_discard;
  logic        out_fn;

  int checks = 0;
  int errors = 0;
  logic [63:0] prev_codes = '0;
  int          prev_cnt = 0;

  always #5 clk = ~clk;

  kgf_filter #(.SLOTS(SLOTS), .ROW_W(ROW_W), .COL_W(COL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .fn_layer_en(fn_layer_en), .ghost_en(ghost_en),
    .fn_code(fn_code), .in_valid(in_valid), .in_ready(in_ready),
    .in_slot_vld(in_slot_vld), .in_rows(in_rows), .in_cols(in_cols),
    .out_valid(out_valid), .out_ready(out_ready), .out_codes(out_codes),
    .out_count(out_count), .out_discard(out_discard), .out_fn(out_fn)
  );

  task automatic chk(input bit ok, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic run_scan(input logic [7:0] v, input logic [31:0] r, input logic [23:0] c,
                          input logic fm, input logic ge, input logic [6:0] fc,
                          input int hold);
    logic [6:0]  lst [8];
    logic [63:0] exp_codes;
    int          cnt, lat, n, exp_cnt;
    logic        fn, disc, rh, ch;
    logic [6:0]  code;
    cnt = 0; fn = 1'b0; disc = 1'b0; rh = 1'b0; ch = 1'b0;
    for (int k = 0; k < 8; k++) lst[k] = '0;
    for (int s = 0; s < 8; s++) begin
      code = {r[s*4 +: 4], c[s*3 +: 3]};
      if (v[s]) begin
        if (fm && code == fc) fn = 1'b1;
        else begin lst[cnt] = code; cnt++; end
      end
    end
    if (ge && cnt >= 3) begin
      for (int i = 0; i < cnt; i++)
        for (int j = i + 1; j < cnt; j++) begin
          if (lst[i][6:3] == lst[j][6:3]) rh = 1'b1;
          if (lst[i][2:0] == lst[j][2:0]) ch = 1'b1;
        end
      disc = rh && ch;
    end
    lat = (ge && cnt >= 3) ? cnt * (cnt - 1) / 2 + 1 : 1;
    if (!disc) begin
      exp_codes = '0;
      for (int k = 0; k < cnt; k++) exp_codes[k*8 +: 8] = {fn, lst[k]};
      prev_codes = exp_codes;
      prev_cnt = cnt;
    end
    exp_codes = prev_codes;
    exp_cnt = prev_cnt;

    @(negedge clk);
    in_slot_vld = v; in_rows = r; in_cols = c;
    fn_layer_en = fm; ghost_en = ge; fn_code = fc; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    n = 0;
    while (!out_valid && n < 100) begin
      @(posedge clk); @(negedge clk); n++;
    end
    chk(n == lat, "R10 latency", 64'(n), 64'(lat));
    chk(out_codes == exp_codes, "R1 R4 R5 R8 codes", out_codes, exp_codes);
    chk(out_count == 4'(exp_cnt), "R5 R8 count", 64'(out_count), 64'(exp_cnt));
    chk(out_discard == disc, "R6 R7 discard", 64'(out_discard), 64'(disc));
    chk(out_fn == fn, "R2 R3 fn flag", 64'(out_fn), 64'(fn));
    for (int h = 0; h < hold; h++) begin
      @(posedge clk); @(negedge clk);
      chk(out_valid && !in_ready && out_codes == exp_codes && out_discard == disc,
          "R9 hold under back-pressure", out_codes, exp_codes);
    end
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    out_ready = 1'b0;
    chk(in_ready && !out_valid, "R9 idle after handoff",
        64'({in_ready, out_valid}), 64'b10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(in_ready && !out_valid && out_count == 0 && out_codes == 0 && !out_discard,
        "R11 reset outputs", out_codes, 64'h0);
    rst_n = 1'b1;
    // R1: single key row 5 col 2 -> 0x2A
    run_scan(8'h01, 32'h5, 24'h2, 1'b0, 1'b1, 7'h07, 2);
    // R7 R8: L-shape (1,1),(1,4),(6,4) discards, repeats previous list
    run_scan(8'h07, {20'h0, 4'h6, 4'h1, 4'h1}, {15'h0, 3'd4, 3'd4, 3'd1}, 1'b0, 1'b1, 7'h07, 1);
    // R6: same scan with ghost check off is kept
    run_scan(8'h07, {20'h0, 4'h6, 4'h1, 4'h1}, {15'h0, 3'd4, 3'd4, 3'd1}, 1'b0, 1'b0, 7'h07, 0);
    // R2 R4: Fn at (0,7) removed, others remapped into upper layer
    run_scan(8'h07, {20'h0, 4'h4, 4'h0, 4'h2}, {15'h0, 3'd5, 3'd7, 3'd3}, 1'b1, 1'b1, 7'h07, 0);
    // R3: Fn mode off keeps that entry as an ordinary key
    run_scan(8'h07, {20'h0, 4'h4, 4'h0, 4'h2}, {15'h0, 3'd5, 3'd7, 3'd3}, 1'b0, 1'b1, 7'h07, 0);
    // R4 R6: Fn completing a ghost pattern is removed first, no discard
    run_scan(8'h07, {20'h0, 4'h5, 4'h0, 4'h0}, {15'h0, 3'd7, 3'd2, 3'd7}, 1'b1, 1'b1, 7'h07, 0);
    // R7 R8: same scan with Fn mode off is a ghost, previous Fn-layer list repeats
    run_scan(8'h07, {20'h0, 4'h5, 4'h0, 4'h0}, {15'h0, 3'd7, 3'd2, 3'd7}, 1'b0, 1'b1, 7'h07, 0);
    // R5: sparse slots compacted
    run_scan(8'hA5, {4'h4, 4'h0, 4'h3, 4'h0, 4'h0, 4'h2, 4'h0, 4'h1},
             {3'd3, 3'd0, 3'd2, 3'd0, 3'd0, 3'd1, 3'd0, 3'd0}, 1'b0, 1'b1, 7'h07, 1);
    // R5: empty scan
    run_scan(8'h00, 32'h0, 24'h0, 1'b0, 1'b1, 7'h07, 0);
    // R7: shared row only is not a ghost
    run_scan(8'h07, {20'h0, 4'h7, 4'h3, 4'h3}, {15'h0, 3'd5, 3'd2, 3'd1}, 1'b0, 1'b1, 7'h07, 0);
    // R10: full eight-key scan, all distinct rows and columns except none
    run_scan(8'hFF, {4'h7, 4'h6, 4'h5, 4'h4, 4'h3, 4'h2, 4'h1, 4'h0},
             {3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0}, 1'b0, 1'b1, 7'h07, 0);
    for (int t = 0; t < 300; t++) begin
      logic [31:0] rr;
      logic [23:0] cc;
      logic [3:0]  rhi;
      logic [2:0]  chi;
      rhi = ($urandom_range(0, 3) == 0) ? 4'd15 : 4'd3;
      chi = ($urandom_range(0, 3) == 0) ? 3'd7 : 3'd3;
      for (int s = 0; s < 8; s++) begin
        rr[s*4 +: 4] = 4'($urandom_range(0, int'(rhi)));
        cc[s*3 +: 3] = 3'($urandom_range(0, int'(chi)));
      end
      run_scan(8'($urandom), rr, cc, 1'($urandom), 1'($urandom),
               {4'($urandom_range(0, 3)), 3'($urandom_range(0, 3))},
               $urandom_range(0, 3));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule